// File: doc/BRIEF.md
# Programmable Sum-of-Products Cell with Polarity Stage

This block is the purely combinational front end of one cell in a programmable logic array. It receives a set of already selected input signals and forms five product terms. Each term is the AND of a programmable choice of literals: the true or inverted form of any input. A static routing setting sends each term to one of three places: the local OR sum, the second input of a polarity XOR, or out of the block as a control term for the register stage that follows.

The OR sum also takes a cascade input from the neighbouring cell. The result leaves on a cascade output, so a chain of cells can build wide sums. An XOR stage then sets the polarity of the sum. Its second input is constant 0, constant 1, or the terms routed to it. The cell also exports a foldback term, the inverse of one chosen product term, which neighbouring cells can share.

All configuration arrives on static input vectors. No state is held inside the block.

Top module: `mc_sum_cell`

## Requirements
- R1: Each product term is the AND of one literal per input. The input's two-bit mask code picks the literal: 2'b01 gives the input itself, 2'b10 gives its inverse, and 2'b00 or 2'b11 leave the input out. An enabled term with no input used is 1.
- R2: A product term whose `ptEnable` bit is 0 is 0, whatever its mask and the inputs.
- R3: A term with route code 2'b00 joins the sum. `cascOut` is the OR of all such terms and `cascIn`.
- R4: A term with route code 2'b01 feeds the XOR operand. A term with route code 2'b10 or 2'b11 appears on its `ctrlTerm` bit. A term not routed 2'b00 adds nothing to the sum, and a `ctrlTerm` bit is 0 unless its term is routed to control.
- R5: With `xorMode` 2'b00, `xorOut` equals the sum. With 2'b01, `xorOut` is the inverted sum.
- R6: With `xorMode` 2'b10 or 2'b11, `xorOut` is the sum XORed with the OR of the terms routed 2'b01. If no term is routed 2'b01, that operand is 0.
- R7: `foldOut` is the inverse of the product term indexed by `foldSel` (0 to 4). Any `foldSel` of 5 or more gives 1.
- R8: `cascIn` at 1 drives `cascOut` to 1 even when every local term is 0 or routed away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inBus | input | N_IN | Selected input signals feeding all product terms |
| maskCfg | input | 5 x N_IN x 2 | Per-term, per-input literal code |
| ptEnable | input | 5 | Per-term enable; 0 forces the term to 0 |
| routeCfg | input | 5 x 2 | Per-term destination: sum, XOR operand or control |
| xorMode | input | 2 | Polarity source: const 0, const 1, or routed terms |
| foldSel | input | 3 | Index of the term whose inverse is exported |
| cascIn | input | 1 | Sum from the neighbouring cell; tie to 0 if unused |
| cascOut | output | 1 | Local OR sum including `cascIn` |
| xorOut | output | 1 | Sum after the polarity XOR |
| ctrlTerm | output | 5 | Product terms routed to control roles |
| foldOut | output | 1 | Inverted chosen product term |

## Verification
The bench targets the literal codes one by one. A design that swapped true and complement, or counted code 2'b11 as a literal, would give the wrong value for a term that uses only one input. It checks that a term with no inputs used is 1 while a disabled term is 0, because an AND-reduction without the enable gate gets the second case wrong. It also checks that terms routed away leave the sum clean, that only the terms routed 2'b01 reach the XOR, and that out-of-range fold indices yield 1. A cell that leaked control terms into the sum, or picked a term from an out-of-range index, would flip `cascOut` or `foldOut`.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // product terms per cell: an architectural constant
  localparam int NUM_PT = 5;
  localparam int FOLD_W = $clog2(NUM_PT);

  // literal codes per input
  localparam logic [1:0] LIT_TRUE = 2'b01;
  localparam logic [1:0] LIT_INV  = 2'b10;

  // route codes per term
  localparam logic [1:0] ROUTE_SUM = 2'b00;
  localparam logic [1:0] ROUTE_XOR = 2'b01;

  // strobes from decode to datapath
  typedef struct packed {
    logic [NUM_PT-1:0] toSum;
    logic [NUM_PT-1:0] toXor;
    logic [NUM_PT-1:0] toCtrl;
    logic [NUM_PT-1:0] foldPick;
    logic              xorUseTerms;
    logic              xorConst;
  } mc_ctrl_t;
endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode
  import mc_pkg::*;
(
  input  logic [NUM_PT-1:0][1:0] routeCfg,
  input  logic [1:0]             xorMode,
  input  logic [FOLD_W-1:0]      foldSel,
  output mc_ctrl_t               ctrl
);
  for (genvar p = 0; p < NUM_PT; p++) begin : g_route
    assign ctrl.toSum[p]    = (routeCfg[p] == ROUTE_SUM);
    assign ctrl.toXor[p]    = (routeCfg[p] == ROUTE_XOR);
    assign ctrl.toCtrl[p]   = routeCfg[p][1];
    assign ctrl.foldPick[p] = (foldSel == FOLD_W'(p));
  end

  assign ctrl.xorUseTerms = xorMode[1];
  assign ctrl.xorConst    = xorMode[0];
endmodule

// File: rtl/mc_term_path.sv
module mc_term_path
  import mc_pkg::*;
#(
  parameter int N_IN = 40
) (
  input  logic [N_IN-1:0]                   inBus,
  input  logic [NUM_PT-1:0][N_IN-1:0][1:0]  maskCfg,
  input  logic [NUM_PT-1:0]                 ptEnable,
  input  logic                              cascIn,
  input  mc_ctrl_t                          ctrl,
  output logic [NUM_PT-1:0]                 ptVec,
  output logic                              sumOut,
  output logic                              xorOut,
  output logic [NUM_PT-1:0]                 ctrlTerm,
  output logic                              foldOut
);
  for (genvar p = 0; p < NUM_PT; p++) begin : g_pt
    logic [N_IN-1:0] lit;
    for (genvar j = 0; j < N_IN; j++) begin : g_lit
      assign lit[j] = (maskCfg[p][j] == LIT_TRUE) ? inBus[j]  :
                      (maskCfg[p][j] == LIT_INV)  ? ~inBus[j] : 1'b1;
    end
    assign ptVec[p] = ptEnable[p] & (&lit);
  end

  logic xorOperand;

  always_comb begin
    sumOut     = (|(ptVec & ctrl.toSum)) | cascIn;
    xorOperand = ctrl.xorUseTerms ? (|(ptVec & ctrl.toXor)) : ctrl.xorConst;
    xorOut     = sumOut ^ xorOperand;
    ctrlTerm   = ptVec & ctrl.toCtrl;
    // no pick (index out of range) leaves the OR at 0, so foldOut is 1
    foldOut    = ~(|(ptVec & ctrl.foldPick));
  end
endmodule

// File: rtl/mc_sum_cell.sv
module mc_sum_cell
  import mc_pkg::*;
#(
  parameter int N_IN = 40
) (
  input  logic [N_IN-1:0]                   inBus,
  input  logic [NUM_PT-1:0][N_IN-1:0][1:0]  maskCfg,
  input  logic [NUM_PT-1:0]                 ptEnable,
  input  logic [NUM_PT-1:0][1:0]            routeCfg,
  input  logic [1:0]                        xorMode,
  input  logic [FOLD_W-1:0]                 foldSel,
  input  logic                              cascIn,
  output logic                              cascOut,
  output logic                              xorOut,
  output logic [NUM_PT-1:0]                 ctrlTerm,
  output logic                              foldOut
);
  mc_ctrl_t          ctrl;
  logic [NUM_PT-1:0] ptVec;

  mc_cfg_decode u_decode (
    .routeCfg (routeCfg),
    .xorMode  (xorMode),
    .foldSel  (foldSel),
    .ctrl     (ctrl)
  );

  mc_term_path #(.N_IN(N_IN)) u_path (
    .inBus    (inBus),
    .maskCfg  (maskCfg),
    .ptEnable (ptEnable),
    .cascIn   (cascIn),
    .ctrl     (ctrl),
    .ptVec    (ptVec),
    .sumOut   (cascOut),
    .xorOut   (xorOut),
    .ctrlTerm (ctrlTerm),
    .foldOut  (foldOut)
  );
endmodule

// File: rtl/mc_sum_cell_chk.sv
module mc_sum_cell_chk
  import mc_pkg::*;
(
  input logic [NUM_PT-1:0]      ptEnable,
  input logic [NUM_PT-1:0][1:0] routeCfg,
  input logic [1:0]             xorMode,
  input logic [FOLD_W-1:0]      foldSel,
  input logic                   cascIn,
  input logic                   cascOut,
  input logic                   xorOut,
  input logic [NUM_PT-1:0]      ctrlTerm,
  input logic                   foldOut
);
  logic anySum;

  always_comb begin
    anySum = 1'b0;
    for (int p = 0; p < NUM_PT; p++) anySum |= (routeCfg[p] == 2'b00);

    p_casc_dominates_r8: assert (!cascIn || cascOut)
      else $error("cascIn high but cascOut low");
    p_no_sum_terms_r3: assert (anySum || cascIn || !cascOut)
      else $error("cascOut high with no sum source");
    p_pass_polarity_r5: assert (xorMode != 2'b00 || xorOut == cascOut)
      else $error("const 0 polarity changed the sum");
    p_inv_polarity_r5: assert (xorMode != 2'b01 || xorOut != cascOut)
      else $error("const 1 polarity did not invert the sum");
    p_fold_range_r7: assert (foldSel < FOLD_W'(NUM_PT) || foldOut)
      else $error("out-of-range fold index gave 0");
    for (int p = 0; p < NUM_PT; p++) begin
      p_ctrl_route_r4: assert (!ctrlTerm[p] || routeCfg[p][1])
        else $error("control term %0d active without control route", p);
      p_ctrl_disabled_r2: assert (ptEnable[p] || !ctrlTerm[p])
        else $error("disabled term %0d reached control output", p);
    end
  end
endmodule

bind mc_sum_cell mc_sum_cell_chk u_chk (
  .ptEnable (ptEnable),
  .routeCfg (routeCfg),
  .xorMode  (xorMode),
  .foldSel  (foldSel),
  .cascIn   (cascIn),
  .cascOut  (cascOut),
  .xorOut   (xorOut),
  .ctrlTerm (ctrlTerm),
  .foldOut  (foldOut)
);

// File: tb/mc_sum_cell_tb.sv
module mc_sum_cell_tb;
  localparam int NI = 40;
  localparam int NP = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [NI-1:0]             inBus;
  logic [NP-1:0][NI-1:0][1:0] maskCfg;
  logic [NP-1:0]             ptEnable;
  logic [NP-1:0][1:0]        routeCfg;
  logic [1:0]                xorMode;
  logic [2:0]                foldSel;
  logic                      cascIn;
  logic                      cascOut, xorOut, foldOut;
  logic [NP-1:0]             ctrlTerm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mc_sum_cell #(.N_IN(NI)) u_dut (
    .inBus(inBus), .maskCfg(maskCfg), .ptEnable(ptEnable), .routeCfg(routeCfg),
    .xorMode(xorMode), .foldSel(foldSel), .cascIn(cascIn),
    .cascOut(cascOut), .xorOut(xorOut), .ctrlTerm(ctrlTerm), .foldOut(foldOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCfg();
    inBus = '0; maskCfg = '0; ptEnable = '0; routeCfg = '0;
    xorMode = 2'b00; foldSel = 3'd0; cascIn = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk); clearCfg(); inBus = 40'hA5_5A5A_A5A5;
    settle();
    check("R2 reset cascOut", 8'(cascOut), 8'd0);
    check("R2 reset xorOut", 8'(xorOut), 8'd0);
    check("R2 reset ctrlTerm", 8'(ctrlTerm), 8'd0);
    check("R7 reset foldOut", 8'(foldOut), 8'd1);
  endtask

  task automatic t_literals();
    @(negedge clk); clearCfg();
    ptEnable = 5'b00111;
    maskCfg[0][3] = 2'b01; maskCfg[0][7] = 2'b10;
    routeCfg[1] = 2'b10;                        // empty mask, control
    routeCfg[2] = 2'b10; maskCfg[2][0] = 2'b11; // 11 means unused
    inBus[3] = 1'b1;
    settle();
    check("R1 true and complement met", 8'(cascOut), 8'd1);
    check("R1 empty mask is 1 and 11 unused", 8'(ctrlTerm), 8'b00110);
    @(negedge clk); inBus[7] = 1'b1;
    settle();
    check("R1 complement literal fails", 8'(cascOut), 8'd0);
    @(negedge clk); inBus[7] = 1'b0; inBus[3] = 1'b0;
    settle();
    check("R1 true literal fails", 8'(cascOut), 8'd0);
  endtask

  task automatic t_disable();
    @(negedge clk); clearCfg();
    routeCfg[0] = 2'b10; ptEnable = 5'b00000;
    settle();
    check("R2 disabled empty term", 8'(ctrlTerm), 8'd0);
    @(negedge clk); ptEnable = 5'b00001;
    settle();
    check("R2 enabled empty term", 8'(ctrlTerm), 8'd1);
  endtask

  task automatic t_sum();
    @(negedge clk); clearCfg(); ptEnable = 5'b11111;
    for (int p = 0; p < NP; p++) maskCfg[p][p] = 2'b01;
    settle();
    check("R3 all sum inputs low", 8'(cascOut), 8'd0);
    for (int p = 0; p < NP; p++) begin
      @(negedge clk); inBus = '0; inBus[p] = 1'b1;
      settle();
      check("R3 single term drives sum", 8'(cascOut), 8'd1);
    end
  endtask

  task automatic t_route();
    @(negedge clk); clearCfg(); ptEnable = 5'b00001; routeCfg[0] = 2'b10;
    settle();
    check("R4 code 10 to control", 8'(ctrlTerm), 8'd1);
    check("R4 control term not in sum", 8'(cascOut), 8'd0);
    @(negedge clk); routeCfg[0] = 2'b11;
    settle();
    check("R4 code 11 to control", 8'(ctrlTerm), 8'd1);
    @(negedge clk); routeCfg[0] = 2'b01;
    settle();
    check("R4 xor term off control", 8'(ctrlTerm), 8'd0);
    check("R4 xor term not in sum", 8'(cascOut), 8'd0);
  endtask

  task automatic t_polarity();
    @(negedge clk); clearCfg(); ptEnable = 5'b00001; maskCfg[0][0] = 2'b01;
    inBus[0] = 1'b1;
    settle();
    check("R5 const 0 passes 1", 8'(xorOut), 8'd1);
    @(negedge clk); xorMode = 2'b01;
    settle();
    check("R5 const 1 inverts 1", 8'(xorOut), 8'd0);
    @(negedge clk); inBus[0] = 1'b0;
    settle();
    check("R5 const 1 inverts 0", 8'(xorOut), 8'd1);
  endtask

  task automatic t_xor_term();
    @(negedge clk); clearCfg(); ptEnable = 5'b00011;
    maskCfg[0][0] = 2'b01; maskCfg[1][1] = 2'b01; routeCfg[1] = 2'b01;
    for (int m = 2; m < 4; m++) begin
      for (int v = 0; v < 4; v++) begin
        @(negedge clk); xorMode = 2'(m); inBus[1:0] = 2'(v);
        settle();
        check("R6 sum xor routed term", 8'(xorOut), 8'(v[0] ^ v[1]));
      end
    end
  endtask

  task automatic t_fold();
    for (int k = 0; k < NP; k++) begin
      @(negedge clk); clearCfg(); ptEnable = '0; ptEnable[k] = 1'b1;
      routeCfg[k] = 2'b10; foldSel = 3'(k);
      settle();
      check("R7 fold of true term", 8'(foldOut), 8'd0);
      @(negedge clk); foldSel = 3'((k + 1) % NP);
      settle();
      check("R7 fold of zero term", 8'(foldOut), 8'd1);
    end
    for (int s = NP; s < 8; s++) begin
      @(negedge clk); clearCfg(); ptEnable = 5'b11111; routeCfg = '1; foldSel = 3'(s);
      settle();
      check("R7 out-of-range fold index", 8'(foldOut), 8'd1);
    end
  endtask

  task automatic t_cascade();
    @(negedge clk); clearCfg(); cascIn = 1'b1;
    settle();
    check("R8 cascIn with no local terms", 8'(cascOut), 8'd1);
    check("R8 cascIn through polarity", 8'(xorOut), 8'd1);
    @(negedge clk); ptEnable = 5'b11111; routeCfg = '1;
    settle();
    check("R8 cascIn with terms routed away", 8'(cascOut), 8'd1);
  endtask

  initial begin
    clearCfg();
    t_reset();
    t_literals();
    t_disable();
    t_sum();
    t_route();
    t_polarity();
    t_xor_term();
    t_fold();
    t_cascade();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule